// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Checker

This block is the issue stage of a statically scheduled, two-way, in-order pipeline. Each fetch packet holds two instructions. The left slot is meant for integer, memory and branch work, and the right slot is meant for floating-point arithmetic. A decoder upstream reduces each instruction to a small record: a class code and up to three register specifiers (one destination and two sources). Each specifier has an enable bit and a bit that selects the integer or the floating-point register file. A scoreboard supplies one busy bit per register in each file, marking registers that an instruction already in flight has yet to write.

Every cycle the checker decides which slots issue. The left slot issues when none of its enabled specifiers names a busy register. The right slot can join it in the same cycle only when all of the following hold:
- the left slot issues;
- the pair has the legal shape;
- the right slot does not depend on the left slot's destination;
- the right slot is itself free of scoreboard hazards.

The right slot is never issued ahead of the left slot. When the left slot issues but the right slot does not, the checker raises fetch hold so that fetch presents the same packet again. It also records, in a one-bit replay state, that the left half is already done. On the next cycle only the right instruction is considered, and it issues alone before any newer packet. When the left slot itself is blocked, nothing issues and the whole packet is retried.

The issue decision is combinational on the presented packet, so fetch hold acts in the same cycle. The only storage is the replay bit.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While `rst` is high, `issue_left`, `issue_right`, `fetch_hold` and `issue_count` are all 0. Reset clears any pending replay, so the first packet after reset is evaluated as a fresh pair.
- R2: An independent legal pair, with no busy registers, issues both slots in one cycle. In that case `issue_count` is 2 and `fetch_hold` is 0.
- R3: Class codes are 0 integer ALU, 1 integer load, 2 integer store, 3 FP load, 4 FP store, 5 FP arithmetic and 6 branch. If the right slot class is not 5, only the left slot may issue that cycle. Hold is raised, and on the next cycle the same packet's right instruction issues alone when it is hazard-free.
- R4: If the left slot class is 5 (FP arithmetic), only the left slot may issue that cycle. The right instruction follows alone on the next cycle.
- R5: If an enabled right-slot source names the same register, in the same file, as the enabled left-slot destination, the right slot is deferred to the next cycle. Specifier bit 0 is the destination, bit 1 is source 1 and bit 2 is source 2; a file-select bit of 1 means the FP file.
- R6: If both slots have enabled destinations naming the same register in the same file, the right slot is deferred to the next cycle.
- R7: Specifiers with equal register numbers in different files never conflict. For example, an FP load whose base is an integer register pairs with an FP operation, because the FP file has separate ports for the load and the arithmetic.
- R8: If any enabled left-slot specifier names a busy register in its file, neither slot issues and hold is raised. No replay is recorded, so once the hazard clears both slots can issue together.
- R9: A deferred right instruction is retried alone on each following cycle, with the left slot never issued again. Hold stays high while the right instruction's own registers remain busy, and it issues as soon as they clear.
- R10: With the left slot invalid and the right slot valid, the right instruction is evaluated alone against the scoreboard. It issues when clear; otherwise it holds.
- R11: With neither slot valid, nothing issues and `fetch_hold` is 0.
- R12: A specifier whose enable bit is 0 is ignored, both for scoreboard busy bits and for the pair dependency checks.
- R13: `issue_count` equals the number of issue enables that are high. `fetch_hold` is high exactly when some valid, not yet issued slot fails to issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_valid | input | 1 | Left slot holds an instruction |
| l_cls | input | 3 | Left slot class code |
| l_rd | input | RW | Left destination register number |
| l_rs1 | input | RW | Left source 1 register number |
| l_rs2 | input | RW | Left source 2 register number |
| l_fpsel | input | 3 | Left per-specifier file select (1 = FP), bit 0 rd, bit 1 rs1, bit 2 rs2 |
| l_use | input | 3 | Left per-specifier enable, same bit order |
| r_valid | input | 1 | Right slot holds an instruction |
| r_cls | input | 3 | Right slot class code |
| r_rd | input | RW | Right destination register number |
| r_rs1 | input | RW | Right source 1 register number |
| r_rs2 | input | RW | Right source 2 register number |
| r_fpsel | input | 3 | Right per-specifier file select |
| r_use | input | 3 | Right per-specifier enable |
| int_busy | input | NREG | Integer registers with a write still in flight |
| fp_busy | input | NREG | FP registers with a write still in flight |
| issue_left | output | 1 | Left instruction issues this cycle |
| issue_right | output | 1 | Right instruction issues this cycle |
| issue_count | output | 2 | Number of instructions issued this cycle |
| fetch_hold | output | 1 | Re-present the same packet next cycle |

## Verification
The bench looks for the following faults:
- Replay ordering. A design that forgot the replay state would issue the left instruction twice. A design that moved on too early would lose the right instruction.
- Register-file select. Ignoring it would falsely serialise pairs that reuse a register number across the two files, such as an FP load with an integer base.
- Disabled specifiers. Honouring them would block on phantom busy registers or phantom dependencies.
- Left-slot stalls. If a left-slot stall were treated as a half issue, the left instruction would be lost, or the pair would be split when the hazard clears.
- Reset in mid-replay. A design that kept the replay bit through reset would skip the left instruction of the next packet.
- Lone right slot. With the left slot empty, the right slot must still stall on its own busy destination.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [2:0] {
    C_INT_ALU   = 3'd0,
    C_INT_LOAD  = 3'd1,
    C_INT_STORE = 3'd2,
    C_FP_LOAD   = 3'd3,
    C_FP_STORE  = 3'd4,
    C_FP_ARITH  = 3'd5,
    C_BRANCH    = 3'd6,
    C_SPARE     = 3'd7
  } op_class_e;

  localparam int NSPEC  = 3;
  localparam int SP_RD  = 0;
  localparam int SP_RS1 = 1;
  localparam int SP_RS2 = 2;
endpackage

// File: rtl/slot_hazard.sv
module slot_hazard #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic [RW-1:0]              rd,
  input  logic [RW-1:0]              rs1,
  input  logic [RW-1:0]              rs2,
  input  logic [dip_pkg::NSPEC-1:0]  fpsel,
  input  logic [dip_pkg::NSPEC-1:0]  use_en,
  input  logic [NREG-1:0]            int_busy,
  input  logic [NREG-1:0]            fp_busy,
  output logic                       clear
);
  logic [RW-1:0]             idx [dip_pkg::NSPEC];
  logic [dip_pkg::NSPEC-1:0] hit;

  assign idx[dip_pkg::SP_RD]  = rd;
  assign idx[dip_pkg::SP_RS1] = rs1;
  assign idx[dip_pkg::SP_RS2] = rs2;

  // one busy lookup per specifier, each in the file its select bit names
  for (genvar g = 0; g < dip_pkg::NSPEC; g++) begin : g_spec
    assign hit[g] = use_en[g] & (fpsel[g] ? fp_busy[idx[g]] : int_busy[idx[g]]);
  end

  assign clear = ~|hit;
endmodule

// File: rtl/pair_rules.sv
module pair_rules #(
  parameter int RW = 5
) (
  input  logic [2:0]                 l_cls,
  input  logic [2:0]                 r_cls,
  input  logic [RW-1:0]              l_rd,
  input  logic                       l_rd_fp,
  input  logic                       l_rd_en,
  input  logic [RW-1:0]              r_rd,
  input  logic [RW-1:0]              r_rs1,
  input  logic [RW-1:0]              r_rs2,
  input  logic [dip_pkg::NSPEC-1:0]  r_fpsel,
  input  logic [dip_pkg::NSPEC-1:0]  r_use,
  output logic                       type_ok,
  output logic                       dep_ok
);
  logic [RW-1:0]             ridx [dip_pkg::NSPEC];
  logic [dip_pkg::NSPEC-1:0] clash;

  assign ridx[dip_pkg::SP_RD]  = r_rd;
  assign ridx[dip_pkg::SP_RS1] = r_rs1;
  assign ridx[dip_pkg::SP_RS2] = r_rs2;

  // legal shape: right is FP arithmetic, left is not
  assign type_ok = (r_cls == dip_pkg::C_FP_ARITH) && (l_cls != dip_pkg::C_FP_ARITH);

  // right destination vs left destination is WAW; right sources vs left destination is RAW
  for (genvar g = 0; g < dip_pkg::NSPEC; g++) begin : g_cmp
    assign clash[g] = r_use[g] & l_rd_en & (r_fpsel[g] == l_rd_fp) & (ridx[g] == l_rd);
  end

  assign dep_ok = ~|clash;
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       l_valid,
  input  logic       r_valid,
  input  logic       l_clear,
  input  logic       r_clear,
  input  logic       type_ok,
  input  logic       dep_ok,
  output logic       iss_l,
  output logic       iss_r,
  output logic       hold,
  output logic [1:0] count
);
  logic replay_q;
  logic left_pend;

  assign left_pend = l_valid & ~replay_q;

  always_comb begin
    iss_l = 1'b0;
    iss_r = 1'b0;
    hold  = 1'b0;
    if (!rst) begin
      iss_l = left_pend & l_clear;
      if (left_pend)
        iss_r = r_valid & iss_l & type_ok & dep_ok & r_clear;
      else
        iss_r = r_valid & r_clear;
      hold = (left_pend & ~iss_l) | (r_valid & ~iss_r);
    end
    count = {1'b0, iss_l} + {1'b0, iss_r};
  end

  always_ff @(posedge clk) begin
    if (rst)
      replay_q <= 1'b0;
    else
      replay_q <= r_valid & ~iss_r & (iss_l | replay_q);
  end

  AST_REPLAY_NO_LEFT: assert property (@(posedge clk) disable iff (rst)
    (iss_l && !iss_r && r_valid) |=> !iss_l); // R9

  AST_FULL_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count == 2'd2) |-> !hold); // R13
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            l_valid,
  input  logic [2:0]      l_cls,
  input  logic [RW-1:0]   l_rd,
  input  logic [RW-1:0]   l_rs1,
  input  logic [RW-1:0]   l_rs2,
  input  logic [2:0]      l_fpsel,
  input  logic [2:0]      l_use,
  input  logic            r_valid,
  input  logic [2:0]      r_cls,
  input  logic [RW-1:0]   r_rd,
  input  logic [RW-1:0]   r_rs1,
  input  logic [RW-1:0]   r_rs2,
  input  logic [2:0]      r_fpsel,
  input  logic [2:0]      r_use,
  input  logic [NREG-1:0] int_busy,
  input  logic [NREG-1:0] fp_busy,
  output logic            issue_left,
  output logic            issue_right,
  output logic [1:0]      issue_count,
  output logic            fetch_hold
);
  logic l_clear, r_clear, type_ok, dep_ok;

  slot_hazard #(.NREG(NREG), .RW(RW)) u_left_hz (
    .rd(l_rd), .rs1(l_rs1), .rs2(l_rs2), .fpsel(l_fpsel), .use_en(l_use),
    .int_busy(int_busy), .fp_busy(fp_busy), .clear(l_clear)
  );

  slot_hazard #(.NREG(NREG), .RW(RW)) u_right_hz (
    .rd(r_rd), .rs1(r_rs1), .rs2(r_rs2), .fpsel(r_fpsel), .use_en(r_use),
    .int_busy(int_busy), .fp_busy(fp_busy), .clear(r_clear)
  );

  pair_rules #(.RW(RW)) u_rules (
    .l_cls(l_cls), .r_cls(r_cls),
    .l_rd(l_rd), .l_rd_fp(l_fpsel[dip_pkg::SP_RD]), .l_rd_en(l_use[dip_pkg::SP_RD]),
    .r_rd(r_rd), .r_rs1(r_rs1), .r_rs2(r_rs2), .r_fpsel(r_fpsel), .r_use(r_use),
    .type_ok(type_ok), .dep_ok(dep_ok)
  );

  issue_ctrl u_ctrl (
    .clk(clk), .rst(rst), .l_valid(l_valid), .r_valid(r_valid),
    .l_clear(l_clear), .r_clear(r_clear), .type_ok(type_ok), .dep_ok(dep_ok),
    .iss_l(issue_left), .iss_r(issue_right), .hold(fetch_hold), .count(issue_count)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (issue_count == 2'd0 && !fetch_hold && !issue_left && !issue_right)); // R1

  AST_PAIR_TYPES: assert property (@(posedge clk) disable iff (rst)
    (issue_left && issue_right) |-> (r_cls == 3'd5 && l_cls != 3'd5)); // R3 R4

  AST_PAIR_NO_RAW: assert property (@(posedge clk) disable iff (rst)
    (issue_left && issue_right && l_use[0] && r_use[1] && (l_fpsel[0] == r_fpsel[1]))
      |-> (r_rs1 != l_rd)); // R5

  AST_LEFT_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
    (issue_left && l_use[1]) |-> !(l_fpsel[1] ? fp_busy[l_rs1] : int_busy[l_rs1])); // R8
endmodule

// File: tb/dual_issue_pair_check_test.sv
`timescale 1ns/100ps
module dual_issue_pair_check_test;
  localparam int NREG = 32;
  localparam int RW   = 5;

  typedef struct packed {
    logic lv; logic [2:0] lc; logic [4:0] lrd, lr1, lr2; logic [2:0] lfp, len;
    logic rv; logic [2:0] rc; logic [4:0] rrd, rr1, rr2; logic [2:0] rfp, ren;
    logic ibe; logic [4:0] ib; logic fbe; logic [4:0] fb;
    logic el, er, eh;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // R2 independent pair
    '{1'b1,3'd0,5'd1,5'd2,5'd3,3'b000,3'b111, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b1,1'b0},
    // R7 same numbers, different files
    '{1'b1,3'd0,5'd7,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd5,5'd9,5'd7,5'd7,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b1,1'b0},
    // R7 FP load with integer base pairs with FP op
    '{1'b1,3'd3,5'd10,5'd2,5'd0,3'b001,3'b011, 1'b1,3'd5,5'd11,5'd12,5'd13,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b1,1'b0},
    // R3 right slot not FP arithmetic, then replay
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd0,5'd2,5'd0,5'd0,3'b000,3'b001, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b0,1'b1},
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd0,5'd2,5'd0,5'd0,3'b000,3'b001, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    // R4 left slot FP arithmetic
    '{1'b1,3'd5,5'd3,5'd0,5'd0,3'b001,3'b001, 1'b1,3'd5,5'd4,5'd0,5'd0,3'b111,3'b001, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b0,1'b1},
    '{1'b1,3'd5,5'd3,5'd0,5'd0,3'b001,3'b001, 1'b1,3'd5,5'd4,5'd0,5'd0,3'b111,3'b001, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    // R5 RAW on right source 2
    '{1'b1,3'd3,5'd5,5'd1,5'd0,3'b001,3'b011, 1'b1,3'd5,5'd6,5'd20,5'd5,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b0,1'b1},
    '{1'b1,3'd3,5'd5,5'd1,5'd0,3'b001,3'b011, 1'b1,3'd5,5'd6,5'd20,5'd5,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    // R6 WAW on FP destination
    '{1'b1,3'd3,5'd8,5'd1,5'd0,3'b001,3'b011, 1'b1,3'd5,5'd8,5'd1,5'd2,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b0,1'b1},
    '{1'b1,3'd3,5'd8,5'd1,5'd0,3'b001,3'b011, 1'b1,3'd5,5'd8,5'd1,5'd2,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    // R8 left source busy: nothing issues, no replay
    '{1'b1,3'd0,5'd1,5'd2,5'd0,3'b000,3'b011, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b1,5'd2,1'b0,5'd0, 1'b0,1'b0,1'b1},
    '{1'b1,3'd0,5'd1,5'd2,5'd0,3'b000,3'b011, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b1,1'b0},
    // R9 right source busy: replay waits, then issues alone
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b1,5'd6, 1'b1,1'b0,1'b1},
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b1,5'd6, 1'b0,1'b0,1'b1},
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    // R10 lone right slot, clear then busy destination
    '{1'b0,3'd0,5'd0,5'd0,5'd0,3'b000,3'b000, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b1,1'b0},
    '{1'b0,3'd0,5'd0,5'd0,5'd0,3'b000,3'b000, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b0,5'd0,1'b1,5'd4, 1'b0,1'b0,1'b1},
    // R11 empty packet
    '{1'b0,3'd0,5'd0,5'd0,5'd0,3'b000,3'b000, 1'b0,3'd0,5'd0,5'd0,5'd0,3'b000,3'b000, 1'b0,5'd0,1'b0,5'd0, 1'b0,1'b0,1'b0},
    // R12 disabled specifiers name busy registers
    '{1'b1,3'd0,5'd1,5'd2,5'd3,3'b000,3'b001, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b011, 1'b1,5'd2,1'b1,5'd6, 1'b1,1'b1,1'b0},
    // R12 disabled left destination matches right source
    '{1'b1,3'd3,5'd5,5'd1,5'd0,3'b001,3'b010, 1'b1,3'd5,5'd6,5'd5,5'd0,3'b111,3'b011, 1'b0,5'd0,1'b0,5'd0, 1'b1,1'b1,1'b0},
    // R8 left destination busy
    '{1'b1,3'd0,5'd1,5'd0,5'd0,3'b000,3'b001, 1'b1,3'd5,5'd4,5'd5,5'd6,3'b111,3'b111, 1'b1,5'd1,1'b0,5'd0, 1'b0,1'b0,1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_valid, r_valid;
  logic [2:0] l_cls, r_cls, l_fpsel, l_use, r_fpsel, r_use;
  logic [RW-1:0] l_rd, l_rs1, l_rs2, r_rd, r_rs1, r_rs2;
  logic [NREG-1:0] int_busy, fp_busy;
  logic issue_left, issue_right, fetch_hold;
  logic [1:0] issue_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_issue_pair_check #(.NREG(NREG), .RW(RW)) uut (
    .clk(clk), .rst(rst),
    .l_valid(l_valid), .l_cls(l_cls), .l_rd(l_rd), .l_rs1(l_rs1), .l_rs2(l_rs2),
    .l_fpsel(l_fpsel), .l_use(l_use),
    .r_valid(r_valid), .r_cls(r_cls), .r_rd(r_rd), .r_rs1(r_rs1), .r_rs2(r_rs2),
    .r_fpsel(r_fpsel), .r_use(r_use),
    .int_busy(int_busy), .fp_busy(fp_busy),
    .issue_left(issue_left), .issue_right(issue_right),
    .issue_count(issue_count), .fetch_hold(fetch_hold)
  );

  task automatic drive(input vec_t v);
    l_valid = v.lv; l_cls = v.lc; l_rd = v.lrd; l_rs1 = v.lr1; l_rs2 = v.lr2;
    l_fpsel = v.lfp; l_use = v.len;
    r_valid = v.rv; r_cls = v.rc; r_rd = v.rrd; r_rs1 = v.rr1; r_rs2 = v.rr2;
    r_fpsel = v.rfp; r_use = v.ren;
    int_busy = '0; fp_busy = '0;
    if (v.ibe) int_busy[v.ib] = 1'b1;
    if (v.fbe) fp_busy[v.fb] = 1'b1;
  endtask

  task automatic check(input string req, input int idx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s step %0d: actual %0d expected %0d", req, idx, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input int idx, input logic el,
                            input logic er, input logic eh);
    check({req, " issue_left"},  idx, int'(issue_left),  int'(el));
    check({req, " issue_right"}, idx, int'(issue_right), int'(er));
    check({req, " fetch_hold"},  idx, int'(fetch_hold),  int'(eh));
    // R13 count follows the enables
    check({"R13 ", req, " issue_count"}, idx, int'(issue_count), int'(el) + int'(er));
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1, 2: return "R7";
      3, 4: return "R3";
      5, 6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6";
      11, 12, 21: return "R8";
      13, 14, 15: return "R9";
      16, 17: return "R10";
      18: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    vec_t idle;
    idle = '0;
    drive(idle);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check_outs("R1 reset", -1, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      #1;
      check_outs(tag_of(i), i, VEC[i].el, VEC[i].er, VEC[i].eh);
      @(negedge clk);
    end
    // R1 reset during a pending replay
    drive(VEC[3]);
    #1;
    check_outs("R1 pre", 100, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check_outs("R1 in reset", 101, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_outs("R1 after reset", 102, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    #1;
    check_outs("R1 replay", 103, 1'b0, 1'b1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule